// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block stores the architectural registers of a small 64-bit processor. It offers two independent read ports and one write port, all usable in the same cycle. Each port is steered by a 4-bit register identifier that is used directly as the storage index.

A read port is purely combinational. Its data output follows its identifier with no clock involved. A write is captured only on the rising clock edge. A read of the register being written in the same cycle therefore shows the old contents until that edge, and the new contents after it.

The all-ones identifier (15) is a "no register" code. It suppresses a write, and it makes a read port return zero. This leaves fifteen real registers, numbered 0 to 14. A synchronous active-low reset clears all of them to zero.

Top module: `regfile_2r1w`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every register 0 to 14 holds zero after that edge.
- R2: Read port A outputs, without waiting for a clock edge, the current contents of the register whose number 0 to 14 is on `rd_a_id`.
- R3: Read port B behaves like port A, independently of it, using `rd_b_id` and `rd_b_data`.
- R4: With `rst_n` high, a write whose `wr_id` is 0 to 14 stores `wr_data` into that register at the rising clock edge, and at no other time.
- R5: A write with `wr_id` equal to 15 changes no register.
- R6: A read port whose identifier is 15 outputs all zeros.
- R7: A read of the register being written in the same cycle returns the old value before the edge and the written value after it.
- R8: Both reads and one write may occur in the same cycle, and a write leaves every register other than its target unchanged.
- R9: Reset takes priority over a write presented in the same cycle, so the written data is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears all registers |
| rd_a_id | input | 4 | Register number for read port A (15 = none) |
| rd_a_data | output | 64 | Contents of the register selected on port A |
| rd_b_id | input | 4 | Register number for read port B (15 = none) |
| rd_b_data | output | 64 | Contents of the register selected on port B |
| wr_id | input | 4 | Destination register number for the write (15 = none) |
| wr_data | input | 64 | Data stored into the destination on the clock edge |

## Verification
The clocked assertions assume that identifiers and write data are settled at every rising edge. They also assume that each cycle carries at most one write request. The bench therefore changes inputs only just after the rising edge, and it compares read outputs at the falling edge, once the combinational read has settled. It sends the null code and every real register number on all three ports. It also overlaps a write with reads of the same register, and it raises a write while reset is low, so that the priority and bypass-free cases are exercised inside those assumptions.

// File: rtl/rf_pkg.sv
// Package: shared sizing constants for the register file.
// Assumes: identifiers are unsigned, and the all-ones code is the null register.
package rf_pkg;
    localparam int RF_DATA_W = 64;
    localparam int RF_ID_W   = 4;
endpackage

// File: rtl/rf_write_decode.sv
// Module: turns the write identifier into a one-hot enable per real register.
// Assumes: the all-ones identifier matches no register, so it yields no enable.
module rf_write_decode #(
    parameter int ID_W     = rf_pkg::RF_ID_W,
    parameter int NUM_REGS = (1 << ID_W) - 1
) (
    input  logic [ID_W-1:0]     wr_id,
    output logic [NUM_REGS-1:0] wr_en
);
    // One comparator per register; the null code is out of range.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign wr_en[i] = (wr_id == ID_W'(i));
    end
endmodule

// File: rtl/rf_storage.sv
// Module: holds the register words and loads them on the rising clock edge.
// Assumes: wr_en has at most one bit set; reset is synchronous and active low.
module rf_storage #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int NUM_REGS = 15
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              wr_en,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        // Clear on reset (which wins over a write), else load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en[i])
                regs_q[i] <= wr_data;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (regs_q == '0));
endmodule

// File: rtl/rf_read_port.sv
// Module: a combinational read port that selects one register word.
// Assumes: an identifier beyond the last register (the null code) reads zero.
module rf_read_port #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W,
    parameter int NUM_REGS = (1 << ID_W) - 1
) (
    input  logic [ID_W-1:0]                  rd_id,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [DATA_W-1:0]                rd_data
);
    // Select the addressed word; default zero covers the null identifier.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_id == ID_W'(i))
                rd_data = regs_q[i];
        end
    end
endmodule

// File: rtl/regfile_2r1w.sv
// Module: top of the two-read one-write register file.
// Assumes: inputs are stable around the rising edge; identifier all-ones is "none".
module regfile_2r1w #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ID_W   = rf_pkg::RF_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NUM_REGS = (1 << ID_W) - 1;
    localparam logic [ID_W-1:0] NULL_ID = '1;

    logic [NUM_REGS-1:0]             wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    rf_write_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec (
        .wr_id (wr_id),
        .wr_en (wr_en)
    );

    rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    rf_read_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_rd_a (
        .rd_id   (rd_a_id),
        .regs_q  (regs_q),
        .rd_data (rd_a_data)
    );

    rf_read_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_rd_b (
        .rd_id   (rd_b_id),
        .regs_q  (regs_q),
        .rd_data (rd_b_data)
    );

    // R5
    null_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id == NULL_ID) |=> $stable(regs_q));

    // R6
    null_read_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_id == NULL_ID) |-> (rd_a_data == '0));

    // R6
    null_read_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_id == NULL_ID) |-> (rd_b_data == '0));

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
        // R4
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_id == ID_W'(k)) |=> (regs_q[k] == $past(wr_data)));

        // R8
        others_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_id != ID_W'(k)) |=> $stable(regs_q[k]));
    end
endmodule

// File: tb/tb_regfile_2r1w.sv
`timescale 1ns/1ps
module tb_regfile_2r1w;
    localparam int DW = 64;
    localparam int IW = 4;
    localparam int NREG = 15;

    typedef struct {
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        string         req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] rd_a_id = 4'hF, rd_b_id = 4'hF, wr_id = 4'hF;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;

    logic [DW-1:0] model [NREG];
    item_t sb_q [$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    regfile_2r1w dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    function automatic logic [DW-1:0] model_rd(input logic [IW-1:0] id);
        return (id == 4'hF) ? '0 : model[id];
    endfunction

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        return {32'(i * 32'h0101_0101 + salt), 32'(~(i * 32'h1357 + salt))};
    endfunction

    // Driver: one cycle of stimulus, pushes the expected reads, updates the model.
    task automatic step(input logic rst, input logic [IW-1:0] wid, input logic [DW-1:0] wd,
                        input logic [IW-1:0] ra, input logic [IW-1:0] rb, input string req);
        item_t it;
        @(posedge clk);
        #1;
        rst_n = rst; wr_id = wid; wr_data = wd; rd_a_id = ra; rd_b_id = rb;
        it.exp_a = model_rd(ra);
        it.exp_b = model_rd(rb);
        it.req = req;
        sb_q.push_back(it);
        if (!rst) begin
            for (int i = 0; i < NREG; i++) model[i] = '0;
        end else if (wid != 4'hF) begin
            model[wid] = wd;
        end
    endtask

    // Monitor: compares settled read outputs against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                vectors += 2;
                if (rd_a_data !== it.exp_a) begin
                    miscompares++;
                    $display("FAIL %s port A: got %h expected %h", it.req, rd_a_data, it.exp_a);
                end
                if (rd_b_data !== it.exp_b) begin
                    miscompares++;
                    $display("FAIL %s port B: got %h expected %h", it.req, rd_b_data, it.exp_b);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        // R1: reset state, every register reads zero.
        for (int i = 0; i < NREG; i++) step(1'b1, 4'hF, '1, 4'(i), 4'(14 - i), "R1");
        // R4/R7: write each register; A reads the target (old), B reads the previous (new).
        for (int i = 0; i < NREG; i++)
            step(1'b1, 4'(i), pat(i, 1), 4'(i), 4'((i + 14) % 15), "R7");
        // R2/R3: independent reads of distinct registers.
        for (int i = 0; i < NREG; i++) step(1'b1, 4'hF, '0, 4'(i), 4'((i * 7) % 15), "R2_R3");
        // R5: null-code write with non-zero data changes nothing.
        step(1'b1, 4'hF, {DW{1'b1}}, 4'd0, 4'd14, "R5");
        for (int i = 0; i < NREG; i++) step(1'b1, 4'hF, '0, 4'(i), 4'(i), "R5");
        // R6: null reads output zero on both ports.
        step(1'b1, 4'hF, '0, 4'hF, 4'hF, "R6");
        step(1'b1, 4'd3, pat(3, 9), 4'hF, 4'd3, "R6");
        // R8/R7: write reg 3 while both ports read it and other registers.
        step(1'b1, 4'd3, pat(3, 42), 4'd3, 4'd7, "R8");
        step(1'b1, 4'd7, pat(7, 42), 4'd3, 4'd7, "R8");
        for (int i = 0; i < NREG; i++) step(1'b1, 4'hF, '0, 4'(i), 4'd3, "R8");
        // R9: write during reset is discarded; R1: all cleared afterwards.
        step(1'b0, 4'd5, pat(5, 77), 4'd5, 4'd0, "R9");
        step(1'b1, 4'hF, '0, 4'd5, 4'd0, "R9");
        for (int i = 0; i < NREG; i++) step(1'b1, 4'hF, '0, 4'(i), 4'(14 - i), "R1");
        step(1'b1, 4'hF, '0, 4'hF, 4'hF, "R6");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule